// File: doc/BRIEF.md
# Vertical Field Divider with Sync Confidence Tracking

This block rebuilds a clean field-rate timing signal from the separated vertical sync of a video input. It runs on the pixel-domain clock and advances a half-line counter on every double-line-rate enable. A controller uses that count to decide when the field ends. For 50 Hz and 60 Hz fields it uses the same state set, with a different table of limits for each rate.

How much the controller trusts the input sync depends on a saturating up/down confidence score. The score rises for each field whose sync lands inside the expected window and falls otherwise. A high score puts the controller in a free-running mode, where it makes the field pulse on its own. A middle score lets only syncs inside a narrow window end the field. A low score lets any sync end the field, with a timeout if no sync arrives. The rate can be forced to 50 Hz or 60 Hz, or left in auto mode, where the rate is taken from where the sync falls.

The outputs are a one-cycle field pulse, a one-cycle sawtooth reset pulse and a level bit that reports the current field rate.

Top module: `vdiv_field_sync`

## Requirements
- R1: While reset is active and after it is released, `field_pulse_o`, `saw_reset_o` and `rate60_o` are 0. The controller starts in the counting state with count 0 and score 0.
- R2: After each field end the count restarts from 0. While the count is below 488 (counting state), vertical sync is ignored and neither pulse is produced. On the enable that takes the count to 488, the controller picks a mode from the score: free-run for score 6 to 7, window for score 3 to 5, open for score 0 to 2.
- R3: In free-run mode the field pulse comes on the enable where the count equals the nominal value (626 at 50 Hz, 526 at 60 Hz), whatever the sync does. The sawtooth reset and the count clear follow one enable later.
- R4: In window mode, a sync seen while the count is strictly between 622 and 628 (522 and 528 at 60 Hz) ends the field on the next enable. Otherwise the field ends when the count equals 628 (528). Ending the field gives the field pulse and the sawtooth reset in the same cycle, and clears the count.
- R5: In open mode, any sync ends the field on the next enable. Without a sync, the field ends when the count reaches 722 if `locked_i` is 1, or 628 (528 at 60 Hz) if it is 0. The count never exceeds 722.
- R6: At each field end the score moves by exactly one step and saturates at 0 and 7. It goes up when a sync fell inside the window during the field, and down otherwise. In free-run and window modes, a good field that directly follows a bad one is scored as bad.
- R7: `force_rate_i` = 2'b10 forces 50 Hz and 2'b01 forces 60 Hz. 2'b00 and 2'b11 select auto mode. In forced mode `rate60_o` takes the forced value at each field end. `rate60_o` changes only together with a sawtooth reset pulse.
- R8: In auto mode, when a sync ends a field in open mode, `rate60_o` becomes 1 if the count was below 576 and 0 otherwise. Every other field end leaves it unchanged.
- R9: `field_pulse_o` and `saw_reset_o` are single-cycle pulses. Each is high only in the clock cycle right after a cycle in which `hl_en_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at 432 times the line rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hl_en_i | input | 1 | One-cycle enable at twice the line rate |
| vsync_i | input | 1 | Separated vertical sync; its rising edge counts |
| locked_i | input | 1 | Horizontal phase loop locked flag |
| force_rate_i | input | 2 | 10: force 50 Hz, 01: force 60 Hz, 00/11: auto |
| field_pulse_o | output | 1 | Generated field pulse, one cycle |
| saw_reset_o | output | 1 | Vertical sawtooth reset, one cycle |
| rate60_o | output | 1 | 1 for 60 Hz, 0 for 50 Hz |

## Verification
The score and the mode cannot be seen directly. A wrong score or a wrong mode choice shows up as a field pulse at the wrong count, on the first field end after the count passes 488. It shows first as a pulse that comes early on a stray sync, or late at the timeout. A wrong rate decision changes the limits used for the next field, so the next field end moves by about 100 counts, and `rate60_o` also differs at the field end where the decision is made. The bench runs a per-enable reference model and compares both pulses and the rate bit on every enable, so a divergence is reported within one field.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  typedef enum logic [2:0] {
    ST_COUNT = 3'd0,
    ST_FREE  = 3'd1,
    ST_WIN   = 3'd2,
    ST_OPEN  = 3'd3,
    ST_WAIT  = 3'd4
  } vd_state_e;

  localparam logic [1:0] FORCE_60 = 2'b01;
  localparam logic [1:0] FORCE_50 = 2'b10;
endpackage

// File: rtl/vdiv_sync_latch.sv
module vdiv_sync_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hl_en_i,
  input  logic vsync_i,
  output logic sync_o
);
  logic vs_q, pend_q, rise;

  assign rise   = vsync_i & ~vs_q;
  assign sync_o = pend_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vs_q   <= vsync_i;
      pend_q <= hl_en_i ? 1'b0 : (pend_q | rise);
    end
  end
endmodule

// File: rtl/vdiv_halfline_cnt.sv
module vdiv_halfline_cnt #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= clr_i ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/vdiv_norm_cnt.sv
module vdiv_norm_cnt #(
  parameter int unsigned NW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          score_i,
  input  logic          good_i,
  input  logic          penal_i,
  output logic [NW-1:0] level_o
);
  localparam logic [NW-1:0] TOP = {NW{1'b1}};

  logic bad_q, up;

  // a good field right after a bad one does not earn credit in strict modes
  assign up = good_i & ~(penal_i & bad_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= '0;
      bad_q   <= 1'b0;
    end else if (score_i) begin
      bad_q <= ~good_i;
      if (up) level_o <= (level_o == TOP) ? level_o : level_o + 1'b1;
      else    level_o <= (level_o == '0)  ? level_o : level_o - 1'b1;
    end
  end
endmodule

// File: rtl/vdiv_ctrl.sv
module vdiv_ctrl
  import vdiv_pkg::*;
#(
  parameter int unsigned CW           = 10,
  parameter int unsigned NW           = 3,
  parameter int unsigned DECIDE_CNT   = 488,
  parameter int unsigned NOM_50       = 626,
  parameter int unsigned LO_50        = 622,
  parameter int unsigned HI_50        = 628,
  parameter int unsigned NOM_60       = 526,
  parameter int unsigned LO_60        = 522,
  parameter int unsigned HI_60        = 528,
  parameter int unsigned LONG_TMO     = 722,
  parameter int unsigned RATE_SPLIT   = 576,
  parameter int unsigned NORM_HI_MIN  = 6,
  parameter int unsigned NORM_MID_MIN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hl_en_i,
  input  logic          sync_i,
  input  logic          locked_i,
  input  logic [1:0]    force_rate_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [NW-1:0] level_i,
  output logic          cnt_clr_o,
  output logic          score_o,
  output logic          good_o,
  output logic          penal_o,
  output logic          field_o,
  output logic          saw_o,
  output logic          rate60_o
);
  localparam logic [CW-1:0] DEC_K   = CW'(DECIDE_CNT);
  localparam logic [CW-1:0] TMO_K   = CW'(LONG_TMO);
  localparam logic [CW-1:0] SPLIT_K = CW'(RATE_SPLIT);
  localparam logic [NW-1:0] HI_LVL  = NW'(NORM_HI_MIN);
  localparam logic [NW-1:0] MID_LVL = NW'(NORM_MID_MIN);

  logic [CW-1:0] nom_t [2];
  logic [CW-1:0] lo_t  [2];
  logic [CW-1:0] hi_t  [2];

  // index 0: 50 Hz limits, index 1: 60 Hz limits
  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam int unsigned NOMV = (g == 0) ? NOM_50 : NOM_60;
    localparam int unsigned LOV  = (g == 0) ? LO_50  : LO_60;
    localparam int unsigned HIV  = (g == 0) ? HI_50  : HI_60;
    assign nom_t[g] = CW'(NOMV);
    assign lo_t[g]  = CW'(LOV);
    assign hi_t[g]  = CW'(HIV);
  end

  vd_state_e     st_q, st_d;
  logic          rate_q, rate_d, hit_q, fld_q, saw_q;
  logic          inwin, fin, fld, by_sync;
  logic [CW-1:0] nom, lo, hi, tmo;

  assign nom   = nom_t[rate_q];
  assign lo    = lo_t[rate_q];
  assign hi    = hi_t[rate_q];
  assign tmo   = locked_i ? TMO_K : hi;
  assign inwin = sync_i && (cnt_i > lo) && (cnt_i < hi);

  always_comb begin
    st_d    = st_q;
    fin     = 1'b0;
    fld     = 1'b0;
    by_sync = 1'b0;
    if (hl_en_i) begin
      unique case (st_q)
        ST_COUNT: begin
          if (cnt_i + 1'b1 == DEC_K) begin
            if (level_i >= HI_LVL)       st_d = ST_FREE;
            else if (level_i >= MID_LVL) st_d = ST_WIN;
            else                         st_d = ST_OPEN;
          end
        end
        ST_FREE: begin
          if (cnt_i == nom) begin
            st_d = ST_WAIT;
            fld  = 1'b1;
          end
        end
        ST_WAIT: fin = 1'b1;
        ST_WIN: begin
          if (inwin || cnt_i == hi) begin
            fin = 1'b1;
            fld = 1'b1;
          end
        end
        ST_OPEN: begin
          if (sync_i) begin
            fin     = 1'b1;
            fld     = 1'b1;
            by_sync = 1'b1;
          end else if (cnt_i == tmo) begin
            fin = 1'b1;
            fld = 1'b1;
          end
        end
        default: st_d = ST_COUNT;
      endcase
      if (fin) st_d = ST_COUNT;
    end
  end

  always_comb begin
    rate_d = rate_q;
    if (fin) begin
      if (force_rate_i == FORCE_60)      rate_d = 1'b1;
      else if (force_rate_i == FORCE_50) rate_d = 1'b0;
      else if (by_sync)                  rate_d = (cnt_i < SPLIT_K);
    end
  end

  assign cnt_clr_o = fin;
  assign score_o   = fin;
  assign good_o    = hit_q | inwin;
  assign penal_o   = (st_q == ST_FREE) || (st_q == ST_WAIT) || (st_q == ST_WIN);
  assign field_o   = fld_q;
  assign saw_o     = saw_q;
  assign rate60_o  = rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_COUNT;
      rate_q <= 1'b0;
      hit_q  <= 1'b0;
      fld_q  <= 1'b0;
      saw_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rate_q <= rate_d;
      fld_q  <= fld;
      saw_q  <= fin;
      if (hl_en_i) hit_q <= fin ? 1'b0 : (hit_q | (inwin & (st_q != ST_COUNT)));
    end
  end
endmodule

// File: rtl/vdiv_field_sync.sv
module vdiv_field_sync
  import vdiv_pkg::*;
#(
  parameter int unsigned DECIDE_CNT   = 488,
  parameter int unsigned NOM_50       = 626,
  parameter int unsigned LO_50        = 622,
  parameter int unsigned HI_50        = 628,
  parameter int unsigned NOM_60       = 526,
  parameter int unsigned LO_60        = 522,
  parameter int unsigned HI_60        = 528,
  parameter int unsigned LONG_TMO     = 722,
  parameter int unsigned RATE_SPLIT   = 576,
  parameter int unsigned NORM_W       = 3,
  parameter int unsigned NORM_HI_MIN  = 6,
  parameter int unsigned NORM_MID_MIN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hl_en_i,
  input  logic       vsync_i,
  input  logic       locked_i,
  input  logic [1:0] force_rate_i,
  output logic       field_pulse_o,
  output logic       saw_reset_o,
  output logic       rate60_o
);
  localparam int unsigned CW = $clog2(LONG_TMO + 1);

  logic              sync_w, clr_w, score_w, good_w, penal_w;
  logic [CW-1:0]     cnt_w;
  logic [NORM_W-1:0] level_w;

  vdiv_sync_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hl_en_i(hl_en_i),
    .vsync_i(vsync_i),
    .sync_o (sync_w)
  );

  vdiv_halfline_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (hl_en_i),
    .clr_i (clr_w),
    .cnt_o (cnt_w)
  );

  vdiv_norm_cnt #(.NW(NORM_W)) u_norm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .score_i(score_w),
    .good_i (good_w),
    .penal_i(penal_w),
    .level_o(level_w)
  );

  vdiv_ctrl #(
    .CW(CW), .NW(NORM_W), .DECIDE_CNT(DECIDE_CNT),
    .NOM_50(NOM_50), .LO_50(LO_50), .HI_50(HI_50),
    .NOM_60(NOM_60), .LO_60(LO_60), .HI_60(HI_60),
    .LONG_TMO(LONG_TMO), .RATE_SPLIT(RATE_SPLIT),
    .NORM_HI_MIN(NORM_HI_MIN), .NORM_MID_MIN(NORM_MID_MIN)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hl_en_i     (hl_en_i),
    .sync_i      (sync_w),
    .locked_i    (locked_i),
    .force_rate_i(force_rate_i),
    .cnt_i       (cnt_w),
    .level_i     (level_w),
    .cnt_clr_o   (clr_w),
    .score_o     (score_w),
    .good_o      (good_w),
    .penal_o     (penal_w),
    .field_o     (field_pulse_o),
    .saw_o       (saw_reset_o),
    .rate60_o    (rate60_o)
  );
endmodule

// File: rtl/vdiv_field_sync_chk.sv
module vdiv_field_sync_chk #(
  parameter int unsigned CW  = 10,
  parameter int unsigned NW  = 3,
  parameter int unsigned TMO = 722
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hl_en_i,
  input logic [1:0]    force_rate_i,
  input logic          field_pulse_o,
  input logic          saw_reset_o,
  input logic          rate60_o,
  input logic [CW-1:0] cnt_i,
  input logic [NW-1:0] level_i
);
  assert_field_after_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_pulse_o |-> $past(hl_en_i));

  assert_saw_after_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    saw_reset_o |-> $past(hl_en_i));

  assert_rate_moves_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate60_o != $past(rate60_o)) |-> saw_reset_o);

  assert_forced_50_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (saw_reset_o && $past(force_rate_i) == 2'b10) |-> !rate60_o);

  assert_forced_60_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (saw_reset_o && $past(force_rate_i) == 2'b01) |-> rate60_o);

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(TMO));

  assert_score_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != $past(level_i)) |-> saw_reset_o);
endmodule

bind vdiv_field_sync vdiv_field_sync_chk #(.CW(CW), .NW(NORM_W), .TMO(LONG_TMO)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hl_en_i      (hl_en_i),
  .force_rate_i (force_rate_i),
  .field_pulse_o(field_pulse_o),
  .saw_reset_o  (saw_reset_o),
  .rate60_o     (rate60_o),
  .cnt_i        (cnt_w),
  .level_i      (level_w)
);

// File: tb/sim_vdiv_field_sync.sv
`timescale 1ns/1ps
module sim_vdiv_field_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hl_en = 1'b0;
  logic       vsync = 1'b0;
  logic       locked = 1'b0;
  logic [1:0] frc = 2'b00;
  logic       fld_o, saw_o, r60_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vdiv_field_sync u0 (
    .clk_i(clk), .rst_ni(rst_n), .hl_en_i(hl_en), .vsync_i(vsync),
    .locked_i(locked), .force_rate_i(frc),
    .field_pulse_o(fld_o), .saw_reset_o(saw_o), .rate60_o(r60_o)
  );

  // reference model, one step per enable; 0 count,1 free,2 window,3 open,4 wait
  int m_st = 0, m_lc = 0, m_nc = 0;
  bit m_bad = 0, m_hit = 0, m_rate = 0;
  bit e_fld, e_saw;
  string e_tag;

  function automatic int lim_nom(bit r); return r ? 526 : 626; endfunction
  function automatic int lim_lo(bit r);  return r ? 522 : 622; endfunction
  function automatic int lim_hi(bit r);  return r ? 528 : 628; endfunction

  function automatic string tag_of(int st);
    case (st)
      0:       return "R2";
      1, 4:    return "R3/score R6";
      2:       return "R4/score R6";
      default: return "R5/score R6";
    endcase
  endfunction

  task automatic model_step(input bit s);
    bit inwin, fin, bysync, good, up;
    int nxt;
    inwin  = s && (m_lc > lim_lo(m_rate)) && (m_lc < lim_hi(m_rate));
    fin    = 0; bysync = 0; e_fld = 0; nxt = m_st;
    e_tag  = tag_of(m_st);
    case (m_st)
      0: if (m_lc + 1 == 488) nxt = (m_nc >= 6) ? 1 : (m_nc >= 3) ? 2 : 3;
      1: if (m_lc == lim_nom(m_rate)) begin nxt = 4; e_fld = 1; end
      4: fin = 1;
      2: if (inwin || m_lc == lim_hi(m_rate)) begin fin = 1; e_fld = 1; end
      default: begin
        if (s) begin fin = 1; e_fld = 1; bysync = 1; end
        else if (m_lc == (locked ? 722 : lim_hi(m_rate))) begin fin = 1; e_fld = 1; end
      end
    endcase
    e_saw = fin;
    if (fin) begin
      good = m_hit || inwin;
      up   = good && !((m_st == 1 || m_st == 2 || m_st == 4) && m_bad);
      if (up) begin if (m_nc < 7) m_nc++; end
      else    begin if (m_nc > 0) m_nc--; end
      m_bad = !good;
      if (frc == 2'b01)      m_rate = 1;
      else if (frc == 2'b10) m_rate = 0;
      else if (bysync)       m_rate = (m_lc < 576);
      m_hit = 0; m_lc = 0; m_st = 0;
    end else begin
      if (inwin && m_st != 0) m_hit = 1;
      m_lc++;
      m_st = nxt;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_pulse(input bit s);
    @(negedge clk);
    chk("R9", "field pulse width", int'(fld_o), 0);
    chk("R9", "saw pulse width", int'(saw_o), 0);
    if (s) vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    @(negedge clk);
    hl_en = 1'b1;
    model_step(s);
    @(negedge clk);
    hl_en = 1'b0;
    chk(e_tag, "field pulse", int'(fld_o), int'(e_fld));
    chk(e_tag, "saw reset", int'(saw_o), int'(e_saw));
    chk((frc == 2'b01 || frc == 2'b10) ? "R7" : "R8", "rate bit", int'(r60_o), int'(m_rate));
  endtask

  int src = 0;
  task automatic run_phase(input int npulse, input int period, input int jit,
                           input int noise, input bit lk, input logic [1:0] fr);
    int gap;
    bit s;
    locked = lk;
    frc    = fr;
    gap    = period;
    for (int i = 0; i < npulse; i++) begin
      s = 0;
      if (period > 0) begin
        src++;
        if (src >= gap) begin
          s   = 1;
          src = 0;
          gap = period + ((jit > 0) ? (int'($urandom % (2 * jit + 1)) - jit) : 0);
        end
      end
      if (noise > 0 && ($urandom % noise) == 0) s = 1;
      do_pulse(s);
    end
  endtask

  initial begin
    void'($urandom(32'd4057));
    repeat (3) @(negedge clk);
    chk("R1", "field in reset", int'(fld_o), 0);
    chk("R1", "saw in reset", int'(saw_o), 0);
    chk("R1", "rate in reset", int'(r60_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "rate after reset", int'(r60_o), 0);
    // directed R2: early syncs ignored while counting
    run_phase(60, 20, 0, 0, 1'b1, 2'b10);
    // clean 50 Hz, forced, locked: climbs to free-run
    run_phase(7500, 625, 0, 0, 1'b1, 2'b10);
    // 60 Hz input in auto mode: score drops, open mode detects rate
    run_phase(6300, 525, 0, 0, 1'b1, 2'b00);
    // random stray syncs, unlocked
    run_phase(3000, 0, 0, 250, 1'b0, 2'b11);
    // forced 60 with jittered 50 Hz input
    run_phase(4000, 625, 2, 0, 1'b1, 2'b01);
    // no sync: short then long timeout
    run_phase(1500, 0, 0, 0, 1'b0, 2'b00);
    run_phase(1500, 0, 0, 0, 1'b1, 2'b00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule